// File: doc/BRIEF.md
# Validated Message Buffer with Wraparound

This block is the word store that sits between the protocol engine of a serial-bus remote terminal and the subsystem it serves. It holds up to 32 words of 16 bits. Received words are written in as the bus decoder strobes them. They stay inside the block until the message is declared good, and then they are paced out to the subsystem one at a time. A message that is declared bad leaves nothing behind. For a transmit command, the decoder pulls words out of the same store. The subsystem filled that store beforehand through a rate-limited load port.

Two receive variants change this flow. In bypass, each accepted word is handed to the subsystem in the cycle after it arrives, with no wait for validation. In wraparound, a receive to subaddress 30 stays in the store and nothing is handed out. A later transmit from subaddress 30 then returns the same words.

Every message begins with a start pulse. The pulse carries the direction, the subaddress and the word count from the command word. Both pointers return to zero at that pulse. A start pulse is honoured in any state and abandons whatever was in progress.

Top module: `msgbuf_top`

## Requirements
- R1: While reset is held and right after it is released, `ss_out_stb` and `ss_in_ack` are low.
- R2: In a normal receive, `ss_out_stb` stays low until `msg_valid`. After `msg_valid`, the accepted words appear on `ss_out_data` in arrival order, one per `ss_out_stb` pulse.
- R3: Successive validated-delivery strobes are exactly DLV_CYC cycles apart. DLV_CYC is 500 ns of clock, which is 8 cycles at the default 16 MHz.
- R4: `msg_err` during a receive discards the buffered words. No validated delivery follows.
- R5: With `bypass_en` set at message start, each accepted received word shows on `ss_out_data` with `ss_out_stb` high in the cycle after `rx_wr` is sampled. The end of the message adds no further strobes, whether it ends in `msg_valid` or `msg_err`.
- R6: With `wrap_en` set, a receive to subaddress 30 (`msg_sa` = 5'd30, `msg_tx` = 0) produces no `ss_out_stb`. A following transmit from subaddress 30 presents the same words in the same order.
- R7: A load strobe `ss_in_stb` is accepted only when no message is in progress and at least LOAD_CYC cycles have passed since the previous acceptance. LOAD_CYC is 1 us of clock, which is 16 cycles at default. Each acceptance raises `ss_in_ack` for one cycle, one cycle later. Any other strobe is ignored and gets no acknowledge.
- R8: After a transmit start, `tx_data` shows the loaded words in load order, beginning with the first. Each `tx_rd` advances it by one word. The load position restarts from the first word at each transmit start.
- R9: A `msg_wc` of 0 means 32 words. Received words beyond the commanded count are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_en | input | 1 | Enables keeping subaddress-30 receive data for loopback |
| bypass_en | input | 1 | Selects word-by-word handover for receives |
| msg_start | input | 1 | One-cycle pulse at the start of a message |
| msg_tx | input | 1 | Direction of the starting message, 1 = transmit |
| msg_sa | input | 5 | Subaddress of the starting message |
| msg_wc | input | 5 | Word count of the starting message, 0 means 32 |
| rx_wr | input | 1 | Received-word strobe from the bus decoder |
| rx_data | input | 16 | Received word |
| msg_valid | input | 1 | Pulse: message passed validation |
| msg_err | input | 1 | Pulse: message failed validation |
| tx_rd | input | 1 | Decoder consumed the current transmit word |
| tx_data | output | 16 | Current transmit word |
| ss_in_stb | input | 1 | Subsystem load strobe |
| ss_in_data | input | 16 | Subsystem load word |
| ss_in_ack | output | 1 | Load accepted |
| ss_out_stb | output | 1 | Word valid toward subsystem |
| ss_out_data | output | 16 | Word toward subsystem |

## Verification
Receive messages are driven from a vector table. The table varies the subaddress, the commanded count against the number of words sent, the ending (good or bad), and the bypass and wrap enables. Comparing the strobe count taken before the end pulse with the count taken after it separates held delivery from bypass. An over-long message and a zero count probe the word limit. A subaddress-30 receive with wrap disabled, and a receive to another subaddress with wrap enabled, show that wraparound needs both conditions. Directed tests cover three more cases: a burst of load strobes every cycle, which must be thinned to one per load period; load strobes raised during a delivery, which must all be refused; and a wraparound receive followed by a transmit from the same subaddress.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_DLV  = 2'd2,
    ST_TX   = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    RM_NORM = 2'd0,
    RM_BYP  = 2'd1,
    RM_WRAP = 2'd2
  } rxm_e;

  // Whole clock cycles covering a span of ns at a given clock rate, at least 1.
  function automatic int ns_to_cyc(input longint hz, input longint ns);
    longint c;
    c = ((hz / 1000) * ns) / 1000000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/msgbuf_mem.sv
module msgbuf_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic hit;
    assign hit = we && (waddr == AW'(i));
    always_ff @(posedge clk) begin
      if (hit) begin
        rows[i] <= wdata;
      end
    end
  end

  assign rdata = rows[raddr];

endmodule

// File: rtl/msgbuf_gap.sv
module msgbuf_gap #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ready
);
  localparam int GW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [GW-1:0] RELOAD = GW'(PERIOD - 1);

  logic [GW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire) begin
      cnt_d = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ready = (cnt_q == '0);

endmodule

// File: rtl/msgbuf_ctrl.sv
module msgbuf_ctrl
  import msgbuf_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DW      = 16,
  parameter int SAW     = 5,
  parameter int WRAP_SA = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrap_en,
  input  logic                     bypass_en,
  input  logic                     msg_start,
  input  logic                     msg_tx,
  input  logic [SAW-1:0]           msg_sa,
  input  logic [$clog2(DEPTH)-1:0] msg_wc,
  input  logic                     rx_wr,
  input  logic [DW-1:0]            rx_data,
  input  logic                     msg_valid,
  input  logic                     msg_err,
  input  logic                     tx_rd,
  input  logic                     ss_in_stb,
  input  logic [DW-1:0]            ss_in_data,
  input  logic                     dlv_ready,
  input  logic                     ld_ready,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     mem_we,
  output logic [$clog2(DEPTH)-1:0] mem_waddr,
  output logic [DW-1:0]            mem_wdata,
  output logic [$clog2(DEPTH)-1:0] mem_raddr,
  output logic                     dlv_fire,
  output logic                     ld_fire,
  output logic                     ss_out_stb,
  output logic [DW-1:0]            ss_out_data,
  output logic                     ss_in_ack,
  output st_e                      st,
  output rxm_e                     rx_mode,
  output logic [$clog2(DEPTH):0]   rx_cnt,
  output logic [$clog2(DEPTH):0]   wc_lim
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0]  DEPTH_C = CW'(DEPTH);
  localparam logic [SAW-1:0] WRAP_C  = SAW'(WRAP_SA);

  st_e            st_q, st_d;
  rxm_e           mode_q, mode_d;
  logic [CW-1:0]  lim_q, lim_d;
  logic [CW-1:0]  wcnt_q, wcnt_d;
  logic [CW-1:0]  rptr_q, rptr_d;
  logic [CW-1:0]  ldp_q, ldp_d;
  logic           ostb_q, ostb_d;
  logic [DW-1:0]  odat_q, odat_d;
  logic           ack_q, ack_d;

  logic [CW-1:0]  lim_cmd;
  logic [CW-1:0]  rptr_inc;
  logic           rx_room;

  assign lim_cmd  = (msg_wc == '0) ? DEPTH_C : {1'b0, msg_wc};
  assign rptr_inc = rptr_q + 1'b1;
  assign rx_room  = (wcnt_q < lim_q);

  // Next-state process
  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    lim_d     = lim_q;
    wcnt_d    = wcnt_q;
    rptr_d    = rptr_q;
    ldp_d     = ldp_q;
    ostb_d    = 1'b0;
    odat_d    = odat_q;
    ack_d     = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = wcnt_q[AW-1:0];
    mem_wdata = rx_data;
    dlv_fire  = 1'b0;
    ld_fire   = 1'b0;

    if (msg_start) begin
      rptr_d = '0;
      wcnt_d = '0;
      lim_d  = lim_cmd;
      if (msg_tx) begin
        st_d  = ST_TX;
        ldp_d = '0;
      end else begin
        st_d = ST_RX;
        if (wrap_en && (msg_sa == WRAP_C)) begin
          mode_d = RM_WRAP;
        end else if (bypass_en) begin
          mode_d = RM_BYP;
        end else begin
          mode_d = RM_NORM;
        end
      end
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (rx_wr && rx_room) begin
            mem_we = 1'b1;
            wcnt_d = wcnt_q + 1'b1;
            if (mode_q == RM_BYP) begin
              ostb_d = 1'b1;
              odat_d = rx_data;
            end
          end
          if (msg_err) begin
            st_d   = ST_IDLE;
            wcnt_d = '0;
          end else if (msg_valid) begin
            if ((mode_q == RM_NORM) && (wcnt_d != '0)) begin
              st_d   = ST_DLV;
              rptr_d = '0;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_DLV: begin
          if (dlv_ready) begin
            ostb_d   = 1'b1;
            odat_d   = mem_rdata;
            dlv_fire = 1'b1;
            rptr_d   = rptr_inc;
            if (rptr_inc >= wcnt_q) begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_TX: begin
          if (msg_err) begin
            st_d = ST_IDLE;
          end else if (tx_rd && (rptr_q < lim_q)) begin
            rptr_d = rptr_inc;
            if (rptr_inc == lim_q) begin
              st_d = ST_IDLE;
            end
          end
        end
        default: begin
          if (ss_in_stb && ld_ready && (ldp_q < DEPTH_C)) begin
            mem_we    = 1'b1;
            mem_waddr = ldp_q[AW-1:0];
            mem_wdata = ss_in_data;
            ldp_d     = ldp_q + 1'b1;
            ack_d     = 1'b1;
            ld_fire   = 1'b1;
          end
        end
      endcase
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= RM_NORM;
      lim_q  <= '0;
      wcnt_q <= '0;
      rptr_q <= '0;
      ldp_q  <= '0;
      ostb_q <= 1'b0;
      odat_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      lim_q  <= lim_d;
      wcnt_q <= wcnt_d;
      rptr_q <= rptr_d;
      ldp_q  <= ldp_d;
      ostb_q <= ostb_d;
      odat_q <= odat_d;
      ack_q  <= ack_d;
    end
  end

  assign mem_raddr   = rptr_q[AW-1:0];
  assign ss_out_stb  = ostb_q;
  assign ss_out_data = odat_q;
  assign ss_in_ack   = ack_q;
  assign st          = st_q;
  assign rx_mode     = mode_q;
  assign rx_cnt      = wcnt_q;
  assign wc_lim      = lim_q;

endmodule

// File: rtl/msgbuf_top.sv
module msgbuf_top
  import msgbuf_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int DW      = 16,
  parameter int SAW     = 5,
  parameter int WRAP_SA = 30,
  parameter int CLK_HZ  = 16_000_000,
  parameter int DLV_NS  = 500,
  parameter int LOAD_NS = 1000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wrap_en,
  input  logic                     bypass_en,
  input  logic                     msg_start,
  input  logic                     msg_tx,
  input  logic [SAW-1:0]           msg_sa,
  input  logic [$clog2(DEPTH)-1:0] msg_wc,
  input  logic                     rx_wr,
  input  logic [DW-1:0]            rx_data,
  input  logic                     msg_valid,
  input  logic                     msg_err,
  input  logic                     tx_rd,
  output logic [DW-1:0]            tx_data,
  input  logic                     ss_in_stb,
  input  logic [DW-1:0]            ss_in_data,
  output logic                     ss_in_ack,
  output logic                     ss_out_stb,
  output logic [DW-1:0]            ss_out_data
);
  localparam int AW       = $clog2(DEPTH);
  localparam int DLV_CYC  = ns_to_cyc(longint'(CLK_HZ), longint'(DLV_NS));
  localparam int LOAD_CYC = ns_to_cyc(longint'(CLK_HZ), longint'(LOAD_NS));

  logic           mem_we;
  logic [AW-1:0]  mem_waddr, mem_raddr;
  logic [DW-1:0]  mem_wdata, mem_rdata;
  logic           dlv_fire, dlv_ready, ld_fire, ld_ready;
  st_e            st_w;
  rxm_e           mode_w;
  logic [AW:0]    rx_cnt_w, wc_lim_w;

  msgbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  msgbuf_gap #(.PERIOD(DLV_CYC)) u_dlv_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (dlv_fire),
    .ready (dlv_ready)
  );

  msgbuf_gap #(.PERIOD(LOAD_CYC)) u_ld_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (ld_fire),
    .ready (ld_ready)
  );

  msgbuf_ctrl #(.DEPTH(DEPTH), .DW(DW), .SAW(SAW), .WRAP_SA(WRAP_SA)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wrap_en     (wrap_en),
    .bypass_en   (bypass_en),
    .msg_start   (msg_start),
    .msg_tx      (msg_tx),
    .msg_sa      (msg_sa),
    .msg_wc      (msg_wc),
    .rx_wr       (rx_wr),
    .rx_data     (rx_data),
    .msg_valid   (msg_valid),
    .msg_err     (msg_err),
    .tx_rd       (tx_rd),
    .ss_in_stb   (ss_in_stb),
    .ss_in_data  (ss_in_data),
    .dlv_ready   (dlv_ready),
    .ld_ready    (ld_ready),
    .mem_rdata   (mem_rdata),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .mem_wdata   (mem_wdata),
    .mem_raddr   (mem_raddr),
    .dlv_fire    (dlv_fire),
    .ld_fire     (ld_fire),
    .ss_out_stb  (ss_out_stb),
    .ss_out_data (ss_out_data),
    .ss_in_ack   (ss_in_ack),
    .st          (st_w),
    .rx_mode     (mode_w),
    .rx_cnt      (rx_cnt_w),
    .wc_lim      (wc_lim_w)
  );

  assign tx_data = mem_rdata;

endmodule

// File: rtl/msgbuf_chk.sv
module msgbuf_chk
  import msgbuf_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int DW       = 16,
  parameter int LOAD_CYC = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   msg_start,
  input logic                   rx_wr,
  input logic [DW-1:0]          rx_data,
  input logic                   ss_out_stb,
  input logic [DW-1:0]          ss_out_data,
  input logic                   ss_in_ack,
  input st_e                    st,
  input rxm_e                   rx_mode,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [$clog2(DEPTH):0] wc_lim
);
  localparam int GW = $clog2(LOAD_CYC + 1) + 1;

  logic [GW-1:0] since_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ack <= GW'(LOAD_CYC);
    end else if (ss_in_ack) begin
      since_ack <= GW'(1);
    end else if (since_ack < GW'(LOAD_CYC)) begin
      since_ack <= since_ack + 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!ss_out_stb && !ss_in_ack)
        else $error("strobe or acknowledge active in reset");
    end
  end

  assert_no_early_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && rx_mode == RM_NORM) |-> !ss_out_stb);

  assert_bypass_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && rx_mode == RM_BYP && rx_wr && !msg_start && (rx_cnt < wc_lim))
      |=> (ss_out_stb && ss_out_data == $past(rx_data)));

  assert_wrap_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && rx_mode == RM_WRAP) |-> !ss_out_stb);

  assert_load_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ss_in_ack |-> (since_ack >= GW'(LOAD_CYC)));

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= wc_lim) && (wc_lim <= ($clog2(DEPTH)+1)'(DEPTH)));

endmodule

bind msgbuf_top msgbuf_chk #(.DEPTH(DEPTH), .DW(DW), .LOAD_CYC(LOAD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_start   (msg_start),
  .rx_wr       (rx_wr),
  .rx_data     (rx_data),
  .ss_out_stb  (ss_out_stb),
  .ss_out_data (ss_out_data),
  .ss_in_ack   (ss_in_ack),
  .st          (st_w),
  .rx_mode     (mode_w),
  .rx_cnt      (rx_cnt_w),
  .wc_lim      (wc_lim_w)
);

// File: tb/sim_msgbuf_top.sv
module sim_msgbuf_top;

  localparam int EXP_DLV  = 8;
  localparam int EXP_LOAD = 16;

  typedef struct packed {
    logic       byp;
    logic       wrp;
    logic [4:0] sa;
    logic [4:0] wc;
    logic [5:0] ns;
    logic       err;
    logic [5:0] ex;
  } vec_t;

  // bypass, wrap, subaddress, count, words sent, error end, expected strobes
  localparam vec_t VT [0:8] = '{
    '{1'b0, 1'b0, 5'd3,  5'd4, 6'd4,  1'b0, 6'd4},
    '{1'b0, 1'b0, 5'd5,  5'd4, 6'd6,  1'b0, 6'd4},
    '{1'b0, 1'b0, 5'd7,  5'd3, 6'd3,  1'b1, 6'd0},
    '{1'b0, 1'b1, 5'd9,  5'd2, 6'd2,  1'b0, 6'd2},
    '{1'b0, 1'b1, 5'd30, 5'd5, 6'd5,  1'b0, 6'd0},
    '{1'b1, 1'b0, 5'd4,  5'd3, 6'd3,  1'b0, 6'd3},
    '{1'b1, 1'b0, 5'd6,  5'd2, 6'd2,  1'b1, 6'd2},
    '{1'b0, 1'b0, 5'd8,  5'd0, 6'd32, 1'b0, 6'd32},
    '{1'b0, 1'b0, 5'd30, 5'd3, 6'd3,  1'b0, 6'd3}
  };

  logic        clk, rst_n;
  logic        wrap_en, bypass_en, msg_start, msg_tx, rx_wr, msg_valid, msg_err, tx_rd;
  logic [4:0]  msg_sa, msg_wc;
  logic [15:0] rx_data, tx_data, ss_in_data, ss_out_data;
  logic        ss_in_stb, ss_in_ack, ss_out_stb;

  int checks, errors, cyc, nlog;
  bit done;
  logic [15:0] log_d [0:255];
  int          log_c [0:255];

  msgbuf_top u0 (
    .clk(clk), .rst_n(rst_n), .wrap_en(wrap_en), .bypass_en(bypass_en),
    .msg_start(msg_start), .msg_tx(msg_tx), .msg_sa(msg_sa), .msg_wc(msg_wc),
    .rx_wr(rx_wr), .rx_data(rx_data), .msg_valid(msg_valid), .msg_err(msg_err),
    .tx_rd(tx_rd), .tx_data(tx_data), .ss_in_stb(ss_in_stb), .ss_in_data(ss_in_data),
    .ss_in_ack(ss_in_ack), .ss_out_stb(ss_out_stb), .ss_out_data(ss_out_data)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  initial nlog = 0;
  always @(negedge clk) begin
    if (ss_out_stb && nlog < 256) begin
      log_d[nlog] = ss_out_data;
      log_c[nlog] = cyc;
      nlog = nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wdat(input int v, input int k);
    return {4'(v), 12'(k * 5 + 1)};
  endfunction

  task automatic pulse_start(input bit tx, input logic [4:0] sa, input logic [4:0] wc);
    @(negedge clk);
    msg_start = 1'b1; msg_tx = tx; msg_sa = sa; msg_wc = wc;
    @(negedge clk);
    msg_start = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] d);
    @(negedge clk);
    rx_wr = 1'b1; rx_data = d;
    @(negedge clk);
    rx_wr = 1'b0;
  endtask

  task automatic end_msg(input bit err);
    @(negedge clk);
    if (err) msg_err = 1'b1; else msg_valid = 1'b1;
    @(negedge clk);
    msg_err = 1'b0; msg_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    automatic int nack;
    automatic logic [15:0] ackd [0:7];
    automatic logic [15:0] drv;
    checks = 0; errors = 0; done = 0;
    wrap_en = 0; bypass_en = 0; msg_start = 0; msg_tx = 0; msg_sa = '0; msg_wc = '0;
    rx_wr = 0; rx_data = '0; msg_valid = 0; msg_err = 0; tx_rd = 0;
    ss_in_stb = 0; ss_in_data = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(!ss_out_stb && !ss_in_ack, "R1", {ss_out_stb, ss_in_ack}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ss_out_stb && !ss_in_ack, "R1", {ss_out_stb, ss_in_ack}, 0);

    // R7/R8: load burst right after reset, strobe every cycle for 40 cycles
    nack = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ss_in_ack && nack < 8) begin
        ackd[nack] = drv;
        nack++;
      end
      drv = 16'h5000 + 16'(i);
      ss_in_stb = 1'b1; ss_in_data = drv;
    end
    @(negedge clk);
    ss_in_stb = 1'b0;
    if (ss_in_ack && nack < 8) begin ackd[nack] = drv; nack++; end
    chk(nack == 3, "R7 ack count", nack, 3);
    for (int k = 0; k < 3; k++)
      chk(ackd[k] == 16'h5000 + 16'(k * EXP_LOAD), "R7 accepted word", ackd[k], 16'h5000 + k * EXP_LOAD);
    // R8: transmit returns loaded words in load order
    pulse_start(1'b1, 5'd12, 5'd3);
    for (int k = 0; k < 3; k++) begin
      chk(tx_data == 16'h5000 + 16'(k * EXP_LOAD), "R8 tx word", tx_data, 16'h5000 + k * EXP_LOAD);
      tx_rd = 1'b1;
      @(negedge clk);
    end
    tx_rd = 1'b0;
    idle(4);

    // Vector table of receive messages (R2, R3, R4, R5, R6, R9)
    for (int v = 0; v < 9; v++) begin
      automatic int b = nlog;
      automatic int lim = (VT[v].wc == 0) ? 32 : int'(VT[v].wc);
      automatic int pre = VT[v].byp ? int'(VT[v].ex) : 0;
      wrap_en = VT[v].wrp; bypass_en = VT[v].byp;
      pulse_start(1'b0, VT[v].sa, VT[v].wc);
      for (int k = 0; k < int'(VT[v].ns); k++) begin
        send_word(wdat(v, k));
        if (VT[v].byp && k < lim)
          chk(ss_out_stb && ss_out_data == wdat(v, k), "R5 bypass echo", ss_out_data, wdat(v, k));
        idle(1);
      end
      chk(nlog - b == pre, VT[v].byp ? "R5 before end" : "R2 held until valid", nlog - b, pre);
      end_msg(VT[v].err);
      idle(300);
      chk(nlog - b == int'(VT[v].ex),
          VT[v].err ? "R4 discard" : (VT[v].wrp ? "R6 wrap" : "R9 word count"),
          nlog - b, VT[v].ex);
      for (int k = 0; k < int'(VT[v].ex) && (b + k) < nlog; k++) begin
        chk(log_d[b + k] == wdat(v, k), "R2 order", log_d[b + k], wdat(v, k));
        if (!VT[v].byp && k > 0)
          chk(log_c[b + k] - log_c[b + k - 1] == EXP_DLV, "R3 spacing",
              log_c[b + k] - log_c[b + k - 1], EXP_DLV);
      end
    end
    wrap_en = 0; bypass_en = 0;

    // R6: wraparound receive then transmit from subaddress 30
    begin
      automatic int b = nlog;
      wrap_en = 1'b1;
      pulse_start(1'b0, 5'd30, 5'd4);
      for (int k = 0; k < 4; k++) send_word(16'hC000 + 16'(k * 7));
      end_msg(1'b0);
      idle(60);
      chk(nlog == b, "R6 no handover", nlog - b, 0);
      pulse_start(1'b1, 5'd30, 5'd4);
      for (int k = 0; k < 4; k++) begin
        chk(tx_data == 16'hC000 + 16'(k * 7), "R6 loopback word", tx_data, 16'hC000 + k * 7);
        tx_rd = 1'b1;
        @(negedge clk);
      end
      tx_rd = 1'b0;
      wrap_en = 1'b0;
      idle(4);
    end

    // R7: load strobes during a delivery are refused
    begin
      automatic int acks = 0;
      pulse_start(1'b0, 5'd2, 5'd6);
      for (int k = 0; k < 6; k++) send_word(16'h7700 + 16'(k));
      end_msg(1'b0);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (ss_in_ack) acks++;
        ss_in_stb = 1'b1; ss_in_data = 16'hDEAD;
      end
      @(negedge clk);
      ss_in_stb = 1'b0;
      if (ss_in_ack) acks++;
      chk(acks == 0, "R7 busy refuse", acks, 0);
      idle(80);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule